// File: doc/BRIEF.md
# Minimised Five-State Mealy Recogniser

This block watches a serial bit stream, one bit per rising clock edge, and drives a single flag. The flag is a Mealy output: it depends on the present state and on the bit currently presented. A seven-state behaviour was folded into five states by merging states that were equivalent, and the block implements that five-state machine. The table is specific to this reduced machine and does not match any named pattern.

The states are held in a three-bit binary register. The names used below are IDLE=000, ONE=001, ONEZERO=010, RUN=011 and TAIL=100. The present state is also driven out on a debug port, so a test environment can follow the state walk. A synchronous active-high reset returns the machine to IDLE. Any of the three spare codes, 101, 110 and 111, returns to IDLE on the next edge.

Top module: `seq_recog_top`

## Requirements
- R1: While `rst` is high at a rising edge, the state after that edge is IDLE (`stateDbg` = 3'b000), from any state.
- R2: From IDLE (000), input 0 stays in IDLE and input 1 moves to ONE (001). The flag is 0 for both inputs.
- R3: From ONE (001), input 0 moves to ONEZERO (010) and input 1 moves to RUN (011). The flag is 0 for both inputs.
- R4: From ONEZERO (010), input 0 moves to IDLE and input 1 moves to RUN. The flag is 0 for both inputs.
- R5: From RUN (011), input 0 moves to TAIL (100) with flag 0. Input 1 stays in RUN with flag 1.
- R6: From TAIL (100), input 0 moves to IDLE with flag 0. Input 1 moves to RUN with flag 1.
- R7: The flag is combinational in the state and the input. Within one clock period it follows a change of `serialIn` while the state is RUN or TAIL, with no clock edge in between.
- R8: Starting from IDLE, the input bits 0,1,0,1,0,1,1,0,1,0,0 produce the flag sequence 0,0,0,0,0,1,1,0,1,0,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| serialIn | input | 1 | Serial data bit, sampled on each rising edge |
| matchOut | output | 1 | Mealy flag for the present state and `serialIn` |
| stateDbg | output | 3 | Present state code, for debug |

## Verification
A wrong next-state entry shows on `stateDbg` one edge after the offending bit. The flag then goes wrong at the first later input that the wrong state treats differently from the right one. That can be as soon as the same cycle, or several bits later if the two states agree for a while. For this reason the bench compares the state code and the flag in every cycle, not only the flag. It also drives every one of the ten state and input pairs, so that no table entry can hide behind a stream that never reaches it.

// File: rtl/seq_recog_pkg.sv
package seq_recog_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE    = 3'b000,
    ST_ONE     = 3'b001,
    ST_ONEZERO = 3'b010,
    ST_RUN     = 3'b011,
    ST_TAIL    = 3'b100
  } recogState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic armed;   // present state lets a 1 raise the flag
  } ctrlStrobe_t;
endpackage

// File: rtl/seq_recog_ctrl.sv
module seq_recog_ctrl
  import seq_recog_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bitIn,
  output ctrlStrobe_t        strobe,
  output logic [STATE_W-1:0] stateCode
);
  recogState_t curState, nxtState;

  always_comb begin
    case (curState)
      ST_IDLE:    nxtState = bitIn ? ST_ONE  : ST_IDLE;
      ST_ONE:     nxtState = bitIn ? ST_RUN  : ST_ONEZERO;
      ST_ONEZERO: nxtState = bitIn ? ST_RUN  : ST_IDLE;
      ST_RUN:     nxtState = bitIn ? ST_RUN  : ST_TAIL;
      ST_TAIL:    nxtState = bitIn ? ST_RUN  : ST_IDLE;
      default:    nxtState = ST_IDLE;  // spare codes recover
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nxtState;
  end

  assign strobe.armed = (curState == ST_RUN) || (curState == ST_TAIL);
  assign stateCode    = curState;

  assert_reset_R1: assert property (@(posedge clk) rst |=> curState == ST_IDLE);
  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_IDLE) |=> (curState == ST_IDLE || curState == ST_ONE));
  assert_one_R3: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_ONE && !bitIn) |=> curState == ST_ONEZERO);
  assert_onezero_R4: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_ONEZERO && bitIn) |=> curState == ST_RUN);
  assert_run_R5: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_RUN && !bitIn) |=> curState == ST_TAIL);
  assert_tail_R6: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_TAIL && !bitIn) |=> curState == ST_IDLE);
endmodule

// File: rtl/seq_recog_dp.sv
module seq_recog_dp
  import seq_recog_pkg::*;
(
  input  ctrlStrobe_t strobe,
  input  logic        bitIn,
  output logic        flag
);
  assign flag = strobe.armed & bitIn;
endmodule

// File: rtl/seq_recog_top.sv
module seq_recog_top
  import seq_recog_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               serialIn,
  output logic               matchOut,
  output logic [STATE_W-1:0] stateDbg
);
  ctrlStrobe_t strobe;

  seq_recog_ctrl uCtrl (
    .clk(clk), .rst(rst), .bitIn(serialIn),
    .strobe(strobe), .stateCode(stateDbg)
  );

  seq_recog_dp uDp (
    .strobe(strobe), .bitIn(serialIn), .flag(matchOut)
  );

  // a raised flag always lands in RUN on the next edge (R5, R6)
  assert_flag_to_run_R5: assert property (@(posedge clk) disable iff (rst)
    matchOut |=> stateDbg == 3'b011);
  // the flag only rises from RUN or TAIL (R7)
  assert_flag_src_R7: assert property (@(posedge clk) disable iff (rst)
    matchOut |-> (stateDbg == 3'b011 || stateDbg == 3'b100));
endmodule

// File: tb/tb_seq_recog_top.sv
module tb_seq_recog_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serialIn = 1'b0;
  logic matchOut;
  logic [2:0] stateDbg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] st;
    logic       fl;
    string      req;
  } expItem_t;
  expItem_t sbQueue[$];
  logic [2:0] modelSt = 3'b000;

  seq_recog_top dut (.clk(clk), .rst(rst), .serialIn(serialIn),
                     .matchOut(matchOut), .stateDbg(stateDbg));

  always #5 clk = ~clk;

  function automatic logic [2:0] nextOf(input logic [2:0] s, input logic b);
    case (s)
      3'b000:  return b ? 3'b001 : 3'b000;
      3'b001:  return b ? 3'b011 : 3'b010;
      3'b010:  return b ? 3'b011 : 3'b000;
      3'b011:  return b ? 3'b011 : 3'b100;
      3'b100:  return b ? 3'b011 : 3'b000;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string reqOf(input logic [2:0] s);
    case (s)
      3'b000:  return "R2";
      3'b001:  return "R3";
      3'b010:  return "R4";
      3'b011:  return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: presents one bit and queues the expected state and flag
  task automatic drive(input logic b, input string tag);
    expItem_t it;
    @(negedge clk);
    serialIn = b;
    it.st  = modelSt;
    it.fl  = ((modelSt == 3'b011) || (modelSt == 3'b100)) && b;
    it.req = (tag == "") ? reqOf(modelSt) : tag;
    sbQueue.push_back(it);
    modelSt = nextOf(modelSt, b);
  endtask

  // monitor: compares in the middle of each low phase
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (sbQueue.size() > 0) begin
        expItem_t it;
        it = sbQueue.pop_front();
        check(it.req, {stateDbg, matchOut}, {it.st, it.fl});
      end
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", {stateDbg, matchOut}, 4'b0000);
    rst = 1'b0;
    modelSt = 3'b000;

    // R8: reference stream
    begin
      logic [10:0] ins  = 11'b00101101010;
      logic [10:0] outs = 11'b00101100000;
      for (int i = 0; i < 11; i++) begin
        @(negedge clk);
        serialIn = ins[i];
        #3;
        check("R8", {3'b000, matchOut}, {3'b000, outs[i]});
      end
      modelSt = nextOf(3'b000, 1'b0);
      modelSt = 3'b000;
    end
    // resync with a reset so the model is exact
    @(negedge clk); rst = 1'b1; serialIn = 1'b0;
    @(negedge clk); rst = 1'b0;
    check("R1", {stateDbg, matchOut}, 4'b0000);
    modelSt = 3'b000;

    // every state and input pair through the scoreboard (R2 to R6)
    drive(0, ""); drive(1, ""); drive(0, ""); drive(0, "");   // a a b c a
    drive(1, ""); drive(1, ""); drive(1, ""); drive(0, "");   // a b d d e
    drive(1, ""); drive(0, ""); drive(0, ""); drive(1, "");   // e d e a b
    drive(0, ""); drive(1, ""); drive(1, ""); drive(0, "");   // c d d e
    drive(0, ""); drive(0, "");

    // R7: flag follows the input between edges in RUN and TAIL
    drive(1, ""); drive(1, "");   // reach RUN
    @(negedge clk);
    sbQueue.delete();
    #1 serialIn = 1'b1; #1 check("R7", {stateDbg, matchOut}, 4'b0111);
    #1 serialIn = 1'b0; #1 check("R7", {stateDbg, matchOut}, 4'b0110);
    @(posedge clk); // RUN with 0 -> TAIL
    @(negedge clk);
    #1 serialIn = 1'b1; #1 check("R7", {stateDbg, matchOut}, 4'b1001);
    #1 serialIn = 1'b0; #1 check("R7", {stateDbg, matchOut}, 4'b1000);

    // R1: reset from TAIL with input 1 present
    serialIn = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1", {stateDbg, 1'b0}, 4'b0000);
    rst = 1'b0; serialIn = 1'b0;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule